// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block collects eight independent event lines into one eight-bit status word that a processor reads over a simple register bus. Each event that occurs while its enable bit is set is captured and held until software reads the word. The read returns the captured bits and then clears them, so each occurrence is reported once. One global mode input chooses how events are captured. In edge mode a bit is set by a low-to-high transition of its source. In level mode a bit is set in every cycle its source is high, so a read while the condition persists leaves the bit set.

The bits, from most to least significant, report these conditions: transmit-side sample slip, output-port sample slip, conversion ratio out of range (input and output rates differ by more than a factor of three in either direction), left-channel over-range, right-channel over-range, first channel-status buffer hand-over, second channel-status buffer hand-over, and receive error. The logic that detects these conditions sits outside this block. A single registered request line goes high whenever any enabled bit is held.

Top module: `sticky_irq_status`

## Requirements
- R1: Bit i of `rd_data` reports event line `evt_src[i]` only, with bit 7 = transmit slip, 6 = output-port slip, 5 = ratio out of range, 4 = left over-range, 3 = right over-range, 2 = first buffer hand-over, 1 = second buffer hand-over, 0 = receive error.
- R2: Once a bit is set it stays 1 until a read clears it, whatever its source does afterwards.
- R3: With `level_mode` = 0 (edge mode), a bit is set at the clock edge that ends a cycle in which its source is 1 and was 0 in the previous cycle. The first cycle after reset counts its previous value as 0. A source that stays high does not set the bit again after it has been cleared.
- R4: With `level_mode` = 1, a bit is set at every clock edge that ends a cycle in which its source is 1, so a read while the source is high does not clear it.
- R5: A bit whose `mask_en` bit is 0 reads as 0 from the next edge on. Clearing the enable discards the held event, so enabling the bit again shows no stale event.
- R6: After reset `rd_data` is 0x00 and `irq` is 0.
- R7: `irq` is registered and equals the OR of all bits of `rd_data` in every cycle.
- R8: `rd_data` always shows the held value, so the value seen in the cycle `rd_stb` is high is the value returned. The clear takes effect at the end of the following cycle and removes only the bits returned. Events that arrive in the strobe cycle or the clear cycle survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_src | input | 8 | Event lines, one per status bit |
| mask_en | input | 8 | Per-bit enable, 1 = bit may be set and read |
| level_mode | input | 1 | 0 = edge capture, 1 = level capture |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_data | output | 8 | Held status word |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that the event lines, enables, mode and read strobe are synchronous to the clock and settle before each edge. They also assume a strobe followed directly by another strobe is legal. The hold property is therefore only applied when no strobe occurred in the current cycle or the cycle before. The stimulus changes every input half a cycle away from the active edge. Random event words are made sparse by AND-ing several random draws, so bits are seen both isolated and overlapping. The capture mode is changed only between long phases, and enables are dropped in occasional random cycles.

// File: rtl/isr_pkg.sv
`timescale 1ns/1ps
package isr_pkg;
    typedef enum logic {
        CAPTURE_EDGE  = 1'b0,
        CAPTURE_LEVEL = 1'b1
    } capture_mode_e;

    localparam int BIT_TX_SLIP    = 7;
    localparam int BIT_PORT_SLIP  = 6;
    localparam int BIT_RATIO_OOR  = 5;
    localparam int BIT_OVR_LEFT   = 4;
    localparam int BIT_OVR_RIGHT  = 3;
    localparam int BIT_CBUF_FIRST = 2;
    localparam int BIT_CBUF_SECND = 1;
    localparam int BIT_RX_ERROR   = 0;
    localparam int STATUS_BITS    = 8;
endpackage

// File: rtl/isr_edge_detect.sv
`timescale 1ns/1ps
module isr_edge_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         level_mode,
    output logic [W-1:0] hit
);
    import isr_pkg::*;

    typedef struct packed {
        logic [W-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    capture_mode_e mode;

    always_comb begin
        mode      = capture_mode_e'(level_mode);
        st_d      = st_q;
        st_d.prev = src;
        if (mode == CAPTURE_LEVEL) begin
            hit = src;
        end else begin
            hit = src & ~st_q.prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/isr_read_tracker.sv
`timescale 1ns/1ps
module isr_read_tracker #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_stb,
    input  logic [W-1:0] cur,
    output logic [W-1:0] clr
);
    typedef struct packed {
        logic         pend;
        logic [W-1:0] snap;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = rd_stb;
        if (rd_stb) begin
            st_d.snap = cur;
        end
        clr = st_q.pend ? st_q.snap : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/isr_bit_cell.sv
`timescale 1ns/1ps
module isr_bit_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic bit_d,
    output logic bit_q
);
    typedef struct packed {
        logic held;
    } cell_state_t;

    cell_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.held = en_i & (set_i | (st_q.held & ~clr_i));
        bit_d     = st_d.held;
        bit_q     = st_q.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sticky_irq_status.sv
`timescale 1ns/1ps
module sticky_irq_status #(
    parameter int W = isr_pkg::STATUS_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_src,
    input  logic [W-1:0] mask_en,
    input  logic         level_mode,
    input  logic         rd_stb,
    output logic [W-1:0] rd_data,
    output logic         irq
);
    typedef struct packed {
        logic req;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;
    logic [W-1:0] stat_d;
    logic [W-1:0] stat_q;

    isr_edge_detect #(.W(W)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (evt_src),
        .level_mode (level_mode),
        .hit        (set_vec)
    );

    isr_read_tracker #(.W(W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_stb (rd_stb),
        .cur    (stat_q),
        .clr    (clr_vec)
    );

    for (genvar i = 0; i < W; i++) begin : g_cell
        isr_bit_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .en_i  (mask_en[i]),
            .bit_d (stat_d[i]),
            .bit_q (stat_q[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.req = |stat_d;
        rd_data  = stat_q;
        irq      = st_q.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/isr_checks.sv
`timescale 1ns/1ps
module isr_checks #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] evt_src,
    input logic [W-1:0] mask_en,
    input logic         level_mode,
    input logic         rd_stb,
    input logic [W-1:0] rd_data,
    input logic         irq
);
    logic [W-1:0] src_q;
    logic         rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            rd_q  <= 1'b0;
        end else begin
            src_q <= evt_src;
            rd_q  <= rd_stb;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (rd_data == '0 && !irq); // R6
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!rd_stb && !rd_q) |=> (($past(rd_data & mask_en) & ~rd_data) == '0)); // R2
    AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n) !level_mode |=> (($past(evt_src & ~src_q & mask_en) & ~rd_data) == '0)); // R3
    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n) level_mode |=> (($past(evt_src & mask_en) & ~rd_data) == '0)); // R4
    AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((rd_data & ~$past(mask_en)) == '0)); // R5
    AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n) irq == (|rd_data)); // R7
endmodule

bind sticky_irq_status isr_checks #(.W(W)) u_chk (.*);

// File: tb/sticky_irq_status_test.sv
`timescale 1ns/1ps
module sticky_irq_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [7:0] evt_src = '0;
    logic [7:0] mask_en = '0;
    logic       level_mode = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_prev = '0;
    logic [7:0] m_st = '0;
    logic [7:0] m_snap = '0;
    logic       m_pend = 1'b0;

    sticky_irq_status uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_src    (evt_src),
        .mask_en    (mask_en),
        .level_mode (level_mode),
        .rd_stb     (rd_stb),
        .rd_data    (rd_data),
        .irq        (irq)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] next_status(input logic [7:0] st, prev, snap, src, msk,
                                               input logic pend, lvl);
        logic [7:0] setv;
        logic [7:0] clrv;
        setv = (lvl ? src : (src & ~prev)) & msk;
        clrv = pend ? snap : 8'h00;
        return ((st & ~clrv) | setv) & msk;
    endfunction

    task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk1(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] s, input logic [7:0] m, input logic l, input logic r);
        evt_src    = s;
        mask_en    = m;
        level_mode = l;
        rd_stb     = r;
        #1;
        chk8(rd_data, m_st, "R8 model rd_data");
        chk1(irq, |m_st, "R7 model irq");
        @(posedge clk);
        m_st   = next_status(m_st, m_prev, m_snap, s, m, m_pend, l);
        if (r) m_snap = m_st_prev_hold;
        m_pend = r;
        m_prev = s;
        @(negedge clk);
    endtask

    logic [7:0] m_st_prev_hold;
    always @(negedge clk) m_st_prev_hold = m_st;

    initial begin
        void'($urandom(32'd4242));
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk8(rd_data, 8'h00, "R6 reset rd_data");
        chk1(irq, 1'b0, "R6 reset irq");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: single pulse on transmit slip lands in bit 7
        step(8'h80, 8'hFF, 1'b0, 1'b0);
        step(8'h00, 8'hFF, 1'b0, 1'b0);
        chk8(rd_data, 8'h80, "R1 bit7 only");
        chk1(irq, 1'b1, "R7 irq raised");
        // R2: held while source idle
        repeat (3) step(8'h00, 8'hFF, 1'b0, 1'b0);
        chk8(rd_data, 8'h80, "R2 sticky hold");
        // R8: read with a new receive error event in the strobe cycle
        step(8'h01, 8'hFF, 1'b0, 1'b1);
        chk8(rd_data, 8'h81, "R8 value during clear cycle");
        step(8'h00, 8'hFF, 1'b0, 1'b0);
        chk8(rd_data, 8'h01, "R8 event in strobe cycle kept");
        step(8'h00, 8'hFF, 1'b0, 1'b1);
        step(8'h00, 8'hFF, 1'b0, 1'b0);
        chk8(rd_data, 8'h00, "R8 cleared after read");
        chk1(irq, 1'b0, "R7 irq dropped");
        // R3: edge mode, source held high, read clears for good
        step(8'h20, 8'hFF, 1'b0, 1'b0);
        chk8(rd_data, 8'h20, "R3 rising edge sets");
        step(8'h20, 8'hFF, 1'b0, 1'b1);
        step(8'h20, 8'hFF, 1'b0, 1'b0);
        step(8'h20, 8'hFF, 1'b0, 1'b0);
        chk8(rd_data, 8'h00, "R3 held source no re-set");
        step(8'h00, 8'hFF, 1'b0, 1'b0);
        // R4: level mode, read while high keeps the bit
        step(8'h04, 8'hFF, 1'b1, 1'b0);
        step(8'h04, 8'hFF, 1'b1, 1'b1);
        step(8'h04, 8'hFF, 1'b1, 1'b0);
        step(8'h04, 8'hFF, 1'b1, 1'b0);
        chk8(rd_data, 8'h04, "R4 level read keeps bit");
        step(8'h00, 8'hFF, 1'b1, 1'b1);
        step(8'h00, 8'hFF, 1'b1, 1'b0);
        step(8'h00, 8'hFF, 1'b1, 1'b0);
        chk8(rd_data, 8'h00, "R4 level cleared once idle");
        // R5: disabled bit never shows, dropped enable discards event
        step(8'h01, 8'hFE, 1'b0, 1'b0);
        step(8'h00, 8'hFE, 1'b0, 1'b0);
        chk8(rd_data, 8'h00, "R5 masked event hidden");
        step(8'h02, 8'hFF, 1'b0, 1'b0);
        step(8'h00, 8'hFD, 1'b0, 1'b0);
        step(8'h00, 8'hFF, 1'b0, 1'b0);
        chk8(rd_data, 8'h00, "R5 no stale event after re-enable");
        chk1(irq, 1'b0, "R7 irq low with no bits");

        // random phase
        for (int ph = 0; ph < 12; ph++) begin
            logic lv;
            lv = ph[0];
            for (int c = 0; c < 250; c++) begin
                logic [7:0] s;
                logic [7:0] m;
                logic r;
                s = 8'($urandom) & 8'($urandom) & 8'($urandom);
                m = (($urandom % 16) == 0) ? 8'($urandom) : 8'hFF;
                r = (($urandom % 8) == 0);
                step(s, m, lv, r);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule